// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block is the data-processing core of a 32-bit integer datapath. It takes two operands and an operation code. Before the second operand reaches the ALU, it goes through an immediate-amount shift stage. The block returns the operation result and a write-enable for the destination register. It also keeps four condition flags in a register: negative, zero, carry and overflow. The result and write-enable are combinational. The flags are registered, and the new values appear one clock after the operation is presented.

The carry flag comes from a different place depending on the operation class. Bitwise operations take it from the bit shifted out of the second operand. Arithmetic operations take it from the adder's top carry. For subtraction that carry is the inverted borrow.

The test and compare variants compute a value only to update the flags, and they never request a register write. A set-flags input decides per operation whether the flag register is updated at all. An incoming carry input supplies the value that an unshifted operand passes on as its carry.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation codes are 0 AND, 1 ORR, 2 EOR, 3 MOV, 4 ADD, 5 SUB, 6 RSB, 7 TST, 8 TEQ and 9 CMP. AND, ORR and EOR combine the first operand with the shifted second operand bitwise. MOV outputs the shifted second operand. All four assert the write-enable.
- R2: ADD outputs A plus shifted B, SUB outputs A minus shifted B, and RSB outputs shifted B minus A. All three wrap modulo 2^32 (0x00000000 minus 0xFFFFFFFF gives 0x00000001) and assert the write-enable.
- R3: Shift type codes are 0 logical left, 1 logical right, 2 arithmetic right (sign-filling) and 3 rotate right. For amounts 1 to 31 the shifted operand follows the selected type.
- R4: The shifter carry depends on the shift type:
  - Logical left by n gives bit 32-n of the operand.
  - Either right shift by n gives bit n-1.
  - Rotate gives bit 31 of the rotated value.
  - An amount of 0, whatever the type, passes the operand through unchanged, and the carry is the incoming carry input.
- R5: For AND, ORR, EOR, MOV, TST and TEQ with set-flags high, C takes the shifter carry and V keeps its previous value.
- R6: For ADD, C is 1 exactly when the unsigned sum exceeds 32 bits. For SUB, RSB and CMP, C is 0 when a borrow occurs and 1 otherwise.
- R7: For ADD, SUB, RSB and CMP, V is the XOR of the carry into bit 31 and the carry out of bit 31, which flags signed overflow.
- R8: With set-flags high and a defined code, N becomes bit 31 of the computed value, and Z becomes 1 exactly when all 32 bits are zero.
- R9: TST computes AND, TEQ computes EOR and CMP computes SUB for the flags only. Their write-enable stays low.
- R10: Flags update at the clock edge after the operation. With set-flags low, all four flags hold.
- R11: Codes 10 to 15 drive a zero result and a low write-enable, and leave the flags unchanged.
- R12: An active-low asynchronous reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, routed through the shifter |
| sh_type_i | input | 2 | Shift type |
| sh_amt_i | input | 5 | Immediate shift amount |
| set_flags_i | input | 1 | Allow the flag register to update |
| c_in_i | input | 1 | Incoming carry, used when the shift amount is 0 |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write request |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
The checker assumes that the inputs hold steady between clock edges. It also assumes that a zero shift amount means a plain pass-through for every shift type, so a zero-amount rotate or right shift is never read as a wide shift.

The carry and overflow properties for addition are written against the raw second operand, so they are enabled only when the shift amount is zero.

The stimulus mixes directed corner cases with random traffic. The directed cases cover wrap-around subtraction, signed overflow, boundary shift amounts and a zero result. About one operation in eight in the random traffic uses an undefined code, to exercise the hold behaviour.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_ORR = 4'd1,
        OP_EOR = 4'd2,
        OP_MOV = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_RSB = 4'd6,
        OP_TST = 4'd7,
        OP_TEQ = 4'd8,
        OP_CMP = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        BW_AND  = 2'd0,
        BW_ORR  = 2'd1,
        BW_EOR  = 2'd2,
        BW_PASS = 2'd3
    } bitwise_fn_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSB) || (op == OP_CMP);
    endfunction

    function automatic logic op_is_bitwise(input logic [3:0] op);
        return (op == OP_AND) || (op == OP_ORR) || (op == OP_EOR) ||
               (op == OP_MOV) || (op == OP_TST) || (op == OP_TEQ);
    endfunction

    function automatic logic op_writes(input logic [3:0] op);
        return (op == OP_AND) || (op == OP_ORR) || (op == OP_EOR) || (op == OP_MOV) ||
               (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSB);
    endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  shift_kind_e      kind_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             c_in_i,
    output logic [WIDTH-1:0] val_o,
    output logic             c_o
);

    localparam logic [SHW:0]     FULL = (SHW+1)'(WIDTH);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [SHW:0]     back_amt;
    logic [SHW-1:0]   amt_m1;
    logic [WIDTH-1:0] lsl_v;
    logic [WIDTH-1:0] lsr_v;
    logic [WIDTH-1:0] asr_v;
    logic [WIDTH-1:0] ror_v;
    logic             left_out;
    logic             right_out;

    assign back_amt  = FULL - {1'b0, amt_i};
    assign amt_m1    = amt_i - 1'b1;
    assign lsl_v     = val_i << amt_i;
    assign lsr_v     = val_i >> amt_i;
    assign asr_v     = WIDTH'($signed(val_i) >>> amt_i);
    assign ror_v     = lsr_v | (val_i << back_amt);
    // last bit pushed past the top, or past the bottom
    assign left_out  = |(val_i & (ONE << back_amt));
    assign right_out = |(val_i & (ONE << amt_m1));

    always_comb begin
        if (amt_i == '0) begin
            val_o = val_i;
            c_o   = c_in_i;
        end else begin
            unique case (kind_i)
                SH_LSL: begin
                    val_o = lsl_v;
                    c_o   = left_out;
                end
                SH_LSR: begin
                    val_o = lsr_v;
                    c_o   = right_out;
                end
                SH_ASR: begin
                    val_o = asr_v;
                    c_o   = right_out;
                end
                default: begin
                    val_o = ror_v;
                    c_o   = ror_v[WIDTH-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_top_in_o,
    output logic             c_out_o
);

    logic [WIDTH:0] cy;

    // generate / propagate carry chain; exposes carry into the top bit
    always_comb begin
        cy[0] = cin_i;
        for (int k = 0; k < WIDTH; k++) begin
            sum_o[k]  = x_i[k] ^ y_i[k] ^ cy[k];
            cy[k+1]   = (x_i[k] & y_i[k]) | ((x_i[k] ^ y_i[k]) & cy[k]);
        end
    end

    assign c_top_in_o = cy[WIDTH-1];
    assign c_out_o    = cy[WIDTH];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  bitwise_fn_e      fn_i,
    output logic [WIDTH-1:0] z_o
);

    always_comb begin
        unique case (fn_i)
            BW_AND:  z_o = x_i & y_i;
            BW_ORR:  z_o = x_i | y_i;
            BW_EOR:  z_o = x_i ^ y_i;
            default: z_o = y_i;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sh_type_i,
    input  logic [SHW-1:0]   sh_amt_i,
    input  logic             set_flags_i,
    input  logic             c_in_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic             n_o,
    output logic             z_o,
    output logic             c_o,
    output logic             v_o
);

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] b_sh;
    logic             sh_carry;
    logic [WIDTH-1:0] add_x, add_y, add_sum;
    logic             add_cin, add_c_top, add_cout;
    bitwise_fn_e      bw_fn;
    logic [WIDTH-1:0] bw_out;
    logic             is_arith, is_bitwise;

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .val_i  (b_i),
        .kind_i (shift_kind_e'(sh_type_i)),
        .amt_i  (sh_amt_i),
        .c_in_i (c_in_i),
        .val_o  (b_sh),
        .c_o    (sh_carry)
    );

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .x_i        (add_x),
        .y_i        (add_y),
        .cin_i      (add_cin),
        .sum_o      (add_sum),
        .c_top_in_o (add_c_top),
        .c_out_o    (add_cout)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bw (
        .x_i  (a_i),
        .y_i  (b_sh),
        .fn_i (bw_fn),
        .z_o  (bw_out)
    );

    assign is_arith   = op_is_arith(op_i);
    assign is_bitwise = op_is_bitwise(op_i);

    always_comb begin
        // adder operand routing: subtraction as x + ~y + 1
        add_x   = a_i;
        add_y   = b_sh;
        add_cin = 1'b0;
        unique case (op_i)
            OP_SUB, OP_CMP: begin
                add_y   = ~b_sh;
                add_cin = 1'b1;
            end
            OP_RSB: begin
                add_x   = b_sh;
                add_y   = ~a_i;
                add_cin = 1'b1;
            end
            default: ;
        endcase

        unique case (op_i)
            OP_ORR:         bw_fn = BW_ORR;
            OP_EOR, OP_TEQ: bw_fn = BW_EOR;
            OP_MOV:         bw_fn = BW_PASS;
            default:        bw_fn = BW_AND;
        endcase

        if (is_arith) begin
            result_o = add_sum;
        end else if (is_bitwise) begin
            result_o = bw_out;
        end else begin
            result_o = '0;
        end
        wr_en_o = op_writes(op_i);

        st_d = st_q;
        if (set_flags_i && (is_arith || is_bitwise)) begin
            st_d.flags.n = result_o[WIDTH-1];
            st_d.flags.z = (result_o == '0);
            if (is_arith) begin
                st_d.flags.c = add_cout;
                st_d.flags.v = add_c_top ^ add_cout;
            end else begin
                st_d.flags.c = sh_carry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign n_o = st_q.flags.n;
    assign z_o = st_q.flags.z;
    assign c_o = st_q.flags.c;
    assign v_o = st_q.flags.v;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       sh_type_i,
    input logic [SHW-1:0]   sh_amt_i,
    input logic             set_flags_i,
    input logic             c_in_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_en_o,
    input logic             n_o,
    input logic             z_o,
    input logic             c_o,
    input logic             v_o
);

    logic [WIDTH:0] wide_sum;
    logic           plain_add;
    logic           known_op;
    logic           bitwise_op;

    assign wide_sum   = {1'b0, a_i} + {1'b0, b_i};
    assign plain_add  = (op_i == 4'd4) && (sh_amt_i == '0) && set_flags_i;
    assign known_op   = (op_i <= 4'd9);
    assign bitwise_op = (op_i <= 4'd3) || (op_i == 4'd7) || (op_i == 4'd8);

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> {n_o, z_o, c_o, v_o} == $past({n_o, z_o, c_o, v_o})); // R10

    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!wr_en_o && result_o == '0)); // R11

    AST_UNUSED_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |=> $stable({n_o, z_o, c_o, v_o})); // R11

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd7 && op_i <= 4'd9) |-> !wr_en_o); // R9

    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && known_op) |=>
            (n_o == $past(result_o[WIDTH-1])) && (z_o == ($past(result_o) == '0))); // R8

    AST_BITWISE_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && bitwise_op) |=> v_o == $past(v_o)); // R5

    AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3 && sh_amt_i == '0) |-> result_o == b_i); // R4

    AST_ZERO_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3 && sh_amt_i == '0 && set_flags_i && sh_type_i <= 2'd3) |=>
            c_o == $past(c_in_i)); // R4

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        plain_add |=> c_o == $past(wide_sum[WIDTH])); // R6

    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        plain_add |=> v_o == $past((a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                                   (wide_sum[WIDTH-1] != a_i[WIDTH-1]))); // R7

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [1:0]  sh_type_i = '0;
    logic [4:0]  sh_amt_i = '0;
    logic        set_flags_i = 1'b0;
    logic        c_in_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic        n_o, z_o, c_o, v_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] ref_flags = '0;
    string      pend_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .sh_type_i(sh_type_i), .sh_amt_i(sh_amt_i), .set_flags_i(set_flags_i),
        .c_in_i(c_in_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // behavioural reference, flags packed as {N,Z,C,V}
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] st, input logic [4:0] amt, input logic ci,
                         input logic sf, input logic [3:0] fin,
                         output logic [31:0] res, output logic we, output logic [3:0] fout);
        logic [31:0] bs;
        logic        sc;
        logic [32:0] w;
        logic        c, v;
        int          n;
        n = int'(amt);
        if (n == 0) begin
            bs = b; sc = ci;
        end else begin
            case (st)
                2'd0: begin bs = b << n; sc = ((b >> (32 - n)) & 32'd1) != 0; end
                2'd1: begin bs = b >> n; sc = ((b >> (n - 1)) & 32'd1) != 0; end
                2'd2: begin bs = 32'($signed(b) >>> n); sc = ((b >> (n - 1)) & 32'd1) != 0; end
                default: begin bs = 32'({b, b} >> n); sc = bs[31]; end
            endcase
        end
        c = 1'b0; v = fin[0]; res = '0; we = 1'b0;
        case (op)
            4'd0, 4'd7: begin res = a & bs; c = sc; end
            4'd1:       begin res = a | bs; c = sc; end
            4'd2, 4'd8: begin res = a ^ bs; c = sc; end
            4'd3:       begin res = bs; c = sc; end
            4'd4: begin
                w = {1'b0, a} + {1'b0, bs};
                res = w[31:0]; c = w[32];
                v = (a[31] == bs[31]) && (res[31] != a[31]);
            end
            4'd5, 4'd9: begin
                res = a - bs; c = (a >= bs);
                v = (a[31] != bs[31]) && (res[31] != a[31]);
            end
            4'd6: begin
                res = bs - a; c = (bs >= a);
                v = (bs[31] != a[31]) && (res[31] != bs[31]);
            end
            default: ;
        endcase
        we = (op <= 4'd6);
        fout = fin;
        if (sf && op <= 4'd9) fout = {res[31], res == 32'd0, c, v};
    endtask

    task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] st, input logic [4:0] amt, input logic sf,
                        input logic ci, input string tag);
        logic [31:0] e_res;
        logic        e_we;
        logic [3:0]  e_fl;
        @(negedge clk);
        check(pend_tag, "flags", {28'd0, n_o, z_o, c_o, v_o}, {28'd0, ref_flags});
        op_i = op; a_i = a; b_i = b; sh_type_i = st; sh_amt_i = amt;
        set_flags_i = sf; c_in_i = ci;
        #1;
        model(op, a, b, st, amt, ci, sf, ref_flags, e_res, e_we, e_fl);
        check(tag, "result", result_o, e_res);
        check((op >= 4'd7 && op <= 4'd9) ? "R9" : tag, "wr_en", {31'd0, wr_en_o}, {31'd0, e_we});
        ref_flags = e_fl;
        pend_tag  = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset clears flags
        check("R12", "flags in reset", {28'd0, n_o, z_o, c_o, v_o}, 32'd0);
        rst_n = 1'b1;

        // R2 R6: wrap-around subtraction borrows, C=0
        step(4'd5, 32'h0000_0000, 32'hFFFF_FFFF, 2'd0, 5'd0, 1'b1, 1'b0, "R2");
        // R7: signed overflow on add
        step(4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 5'd0, 1'b1, 1'b0, "R7");
        // R5: bitwise keeps V (still 1), C from shifter
        step(4'd0, 32'hFFFF_FFFF, 32'h8000_0000, 2'd0, 5'd1, 1'b1, 1'b0, "R5");
        // R6 R8: unsigned carry, zero result
        step(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 2'd0, 5'd0, 1'b1, 1'b0, "R8");
        // R4: zero amount passes through with incoming carry, rotate type
        step(4'd3, 32'h0, 32'h1234_5678, 2'd3, 5'd0, 1'b1, 1'b1, "R4");
        // R3 R4: shifts at boundary amounts
        step(4'd3, 32'h0, 32'h0000_0018, 2'd1, 5'd4, 1'b1, 1'b0, "R3");
        step(4'd3, 32'h0, 32'h8000_0001, 2'd2, 5'd1, 1'b1, 1'b0, "R4");
        step(4'd3, 32'h0, 32'h0000_00F1, 2'd3, 5'd8, 1'b1, 1'b0, "R3");
        step(4'd3, 32'h0, 32'h0000_0003, 2'd0, 5'd31, 1'b1, 1'b0, "R4");
        step(4'd3, 32'h0, 32'h8000_0000, 2'd1, 5'd31, 1'b1, 1'b0, "R3");
        // R1: bitwise ops
        step(4'd1, 32'hF0F0_0000, 32'h0000_0F0F, 2'd0, 5'd0, 1'b1, 1'b0, "R1");
        step(4'd2, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 2'd0, 5'd0, 1'b1, 1'b0, "R1");
        // R2 R6: reverse subtract without borrow
        step(4'd6, 32'h0000_0003, 32'h0000_0010, 2'd0, 5'd0, 1'b1, 1'b0, "R6");
        // R9: compare equal -> Z=1 C=1, no write; test ops
        step(4'd9, 32'h0000_0055, 32'h0000_0055, 2'd0, 5'd0, 1'b1, 1'b0, "R9");
        step(4'd7, 32'h0000_00F0, 32'h0000_000F, 2'd0, 5'd0, 1'b1, 1'b1, "R9");
        step(4'd8, 32'h8000_0000, 32'h0000_0001, 2'd0, 5'd0, 1'b1, 1'b0, "R9");
        // R10: set-flags low holds flags
        step(4'd5, 32'h0, 32'h1, 2'd0, 5'd0, 1'b0, 1'b0, "R10");
        // R11: undefined code
        step(4'd15, 32'h1234, 32'h5678, 2'd0, 5'd0, 1'b1, 1'b1, "R11");
        step(4'd10, 32'h0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, "R11");

        // random traffic over all requirements
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            string      tg;
            if ($urandom_range(0, 7) == 0) op = 4'($urandom_range(10, 15));
            else op = 4'($urandom_range(0, 9));
            if (op > 4'd9) tg = "R11";
            else if (op == 4'd4 || op == 4'd5 || op == 4'd6 || op == 4'd9) tg = "R6";
            else tg = "R5";
            step(op, $urandom, ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
                 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(0, 31)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), tg);
        end

        @(negedge clk);
        check(pend_tag, "flags", {28'd0, n_o, z_o, c_o, v_o}, {28'd0, ref_flags});
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule